// File: doc/BRIEF.md
# Eight-Operand Carry-Save Adder Tree with 4:2 Compressors

This block adds eight unsigned operands of W bits each and returns their exact total. The operands pass through two levels of 4:2 compressors. Each level halves the number of rows, so eight rows become four and then two. A carry-propagate adder then merges the last two rows into one binary sum. The result goes into a register, so the sum of the operands presented before a rising clock edge appears at the output one cycle later.

Each compressor cell adds four bits of equal weight and a carry-in that comes from its right-hand neighbour in the same row. It produces a sum bit, a carry bit of double weight and a carry-out of double weight. The carry-out is formed only from three of the four operand bits, and never from the carry-in. Because of this, a carry travels at most one position sideways and no carry chain forms along a row. The sum bit passes through three XOR levels.

Each row widens its vectors by one bit, so no carry is lost at the top. This makes the result W+3 bits wide, which holds the largest possible total.

Top module: `mop_tree_top`

## Requirements
- R1: One clock after a rising edge at which reset is low, `sum_q` equals the arithmetic sum of the eight W-bit fields of `opnd_flat` sampled at that edge. Field k occupies bits [k*W+W-1 : k*W].
- R2: For every input combination, each compressor cell keeps the weight: a+b+c+d+cin = s + 2*(carry + cout).
- R3: A compressor's `cout` is 1 exactly when at least two of a, b and c are 1. It does not depend on d or on cin.
- R4: A compressor's `s` equals the XOR of all five of its inputs.
- R5: While `rst` is high at a rising edge, `sum_q` becomes 0 at that edge.
- R6: When all eight operands are zero, the next `sum_q` is 0.
- R7: When all eight operands are all ones, the next `sum_q` is 8*(2^W-1). The top result bit is set and no carry is lost.
- R8: When all operands equal 1, the next `sum_q` is 8. This shows that the carry-in of the least significant column is 0 and that low-order carries reach bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| opnd_flat | input | 8*W | Eight packed unsigned operands; field k at bits k*W+W-1 : k*W |
| sum_q | output | W+3 | Registered sum of the eight operands |

## Verification
The all-ones case fills every column to the limit. A design that drops the carry-out of the top cell, or that fails to widen a level, returns a total that is too small by a power of two. The all-value-1 case and the single-operand cases catch a bottom carry-in tied high and an operand field taken from the wrong bit range. The compressor cell is also driven through all 32 of its input combinations. A carry-out that takes cin as an input, or a carry or sum that is swapped or inverted, then breaks the weight balance. A reset applied partway through the run must clear the output even though nonzero operands are still applied.

// File: rtl/mop_pkg.sv
package mop_pkg;
  localparam int unsigned NUM_OPS  = 8;
  localparam int unsigned ROWS_L1  = NUM_OPS / 2;
  localparam int unsigned GROUP_SZ = 4;
  localparam int unsigned GROW     = 3;
endpackage

// File: rtl/csa42_cell.sv
module csa42_cell (
  input  logic a,
  input  logic b,
  input  logic c,
  input  logic d,
  input  logic cin,
  output logic s,
  output logic carry,
  output logic cout
);
  logic ab_x;
  logic cd_x;
  logic mid_x;

  // level 1 XORs
  always_comb begin
    ab_x = a ^ b;
    cd_x = c ^ d;
  end

  // level 2 XOR
  always_comb mid_x = ab_x ^ cd_x;

  // level 3 XOR on the sum path; carry and cout are mux-selected
  always_comb begin
    s     = mid_x ^ cin;
    carry = mid_x ? cin : d;
    cout  = ab_x ? c : a;
  end
endmodule

// File: rtl/csa42_row.sv
module csa42_row #(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0] in0,
  input  logic [N-1:0] in1,
  input  logic [N-1:0] in2,
  input  logic [N-1:0] in3,
  output logic [N:0]   row_s,
  output logic [N:0]   row_c
);
  logic [N-1:0] s_v;
  logic [N-1:0] c_v;
  logic [N-1:0] co_v;
  logic [N-1:0] ci_v;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_bit
      if (i == 0) begin : g_lsb
        assign ci_v[i] = 1'b0;
      end else begin : g_up
        assign ci_v[i] = co_v[i-1];
      end
      csa42_cell u_cell (
        .a    (in0[i]),
        .b    (in1[i]),
        .c    (in2[i]),
        .d    (in3[i]),
        .cin  (ci_v[i]),
        .s    (s_v[i]),
        .carry(c_v[i]),
        .cout (co_v[i])
      );
    end
  endgenerate

  assign row_s = {co_v[N-1], s_v};
  assign row_c = {c_v, 1'b0};
endmodule

// File: rtl/cpa_adder.sv
module cpa_adder #(
  parameter int unsigned N = 18
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  output logic [N:0]   z
);
  always_comb z = {1'b0, x} + {1'b0, y};
endmodule

// File: rtl/mop_tree_top.sv
module mop_tree_top #(
  parameter int unsigned W = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [mop_pkg::NUM_OPS*W-1:0]   opnd_flat,
  output logic [W+mop_pkg::GROW-1:0]      sum_q
);
  import mop_pkg::*;

  localparam int unsigned W1 = W + 1;
  localparam int unsigned W2 = W + 2;
  localparam int unsigned WR = W + GROW;

  logic [ROWS_L1*W1-1:0] l1_flat;
  logic [W2-1:0]         l2_s;
  logic [W2-1:0]         l2_c;
  logic [WR-1:0]         total;

  genvar g;
  generate
    for (g = 0; g < NUM_OPS / GROUP_SZ; g++) begin : g_lvl1
      csa42_row #(.N(W)) u_row (
        .in0  (opnd_flat[(g*GROUP_SZ+0)*W +: W]),
        .in1  (opnd_flat[(g*GROUP_SZ+1)*W +: W]),
        .in2  (opnd_flat[(g*GROUP_SZ+2)*W +: W]),
        .in3  (opnd_flat[(g*GROUP_SZ+3)*W +: W]),
        .row_s(l1_flat[(2*g+0)*W1 +: W1]),
        .row_c(l1_flat[(2*g+1)*W1 +: W1])
      );
    end
  endgenerate

  csa42_row #(.N(W1)) u_lvl2 (
    .in0  (l1_flat[0*W1 +: W1]),
    .in1  (l1_flat[1*W1 +: W1]),
    .in2  (l1_flat[2*W1 +: W1]),
    .in3  (l1_flat[3*W1 +: W1]),
    .row_s(l2_s),
    .row_c(l2_c)
  );

  cpa_adder #(.N(W2)) u_cpa (
    .x(l2_s),
    .y(l2_c),
    .z(total)
  );

  always_ff @(posedge clk) begin
    if (rst) sum_q <= '0;
    else     sum_q <= total;
  end
endmodule

// File: rtl/mop_tree_chk.sv
module mop_tree_chk #(
  parameter int unsigned W = 16
) (
  input logic                          clk,
  input logic                          rst,
  input logic [mop_pkg::NUM_OPS*W-1:0] opnd_flat,
  input logic [W+mop_pkg::GROW-1:0]    sum_q
);
  import mop_pkg::*;
  localparam int unsigned WR = W + GROW;

  function automatic logic [WR-1:0] add_all(input logic [NUM_OPS*W-1:0] v);
    logic [WR-1:0] acc;
    acc = '0;
    for (int k = 0; k < NUM_OPS; k++) acc = acc + WR'(v[k*W +: W]);
    return acc;
  endfunction

  localparam logic [WR-1:0] FULL_SUM = WR'(NUM_OPS) * ((WR'(1) << W) - WR'(1));

  p_reset_clear_r5: assert property (@(posedge clk) rst |=> (sum_q == '0));

  p_exact_sum_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (sum_q == $past(add_all(opnd_flat))));

  p_zero_in_r6: assert property (@(posedge clk) disable iff (rst)
    (opnd_flat == '0) |=> (sum_q == '0));

  p_full_in_r7: assert property (@(posedge clk) disable iff (rst)
    (&opnd_flat) |=> (sum_q == FULL_SUM));
endmodule

module csa42_cell_chk (
  input logic a,
  input logic b,
  input logic c,
  input logic d,
  input logic cin,
  input logic s,
  input logic carry,
  input logic cout
);
  always_comb begin
    if (!$isunknown({a, b, c, d, cin})) begin
      p_weight_r2: assert ((3'(a) + 3'(b) + 3'(c) + 3'(d) + 3'(cin)) ==
                           (3'(s) + 3'({carry, 1'b0}) + 3'({cout, 1'b0})));
      p_cout_free_r3: assert (cout == ((2'(a) + 2'(b) + 2'(c)) >= 2'd2));
      p_sum_parity_r4: assert (s == ^{a, b, c, d, cin});
    end
  end
endmodule

bind mop_tree_top mop_tree_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .opnd_flat(opnd_flat), .sum_q(sum_q)
);

bind csa42_cell csa42_cell_chk u_cell_chk (
  .a(a), .b(b), .c(c), .d(d), .cin(cin), .s(s), .carry(carry), .cout(cout)
);

// File: tb/mop_tree_top_bench.sv
module mop_tree_top_bench;
  localparam int unsigned W      = 16;
  localparam int unsigned NOPS   = 8;
  localparam int unsigned WR     = W + 3;
  localparam time         CLK_PER = 10ns;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [NOPS*W-1:0]    opnd = '0;
  logic [WR-1:0]        sum_q;

  logic ca, cb, cc, cd, cci, cs, ccar, ccout;

  int vectors = 0;
  int miscompares = 0;
  longint exp_q[$];

  always #(CLK_PER/2) clk = ~clk;

  mop_tree_top #(.W(W)) u_mop_tree_top (
    .clk(clk), .rst(rst), .opnd_flat(opnd), .sum_q(sum_q)
  );

  csa42_cell u_cell_alone (
    .a(ca), .b(cb), .c(cc), .d(cd), .cin(cci),
    .s(cs), .carry(ccar), .cout(ccout)
  );

  function automatic longint ref_sum(input logic [NOPS*W-1:0] v);
    longint acc = 0;
    for (int k = 0; k < NOPS; k++) acc += longint'(v[k*W +: W]);
    return acc;
  endfunction

  task automatic check(input string req, input longint got, input longint want);
    vectors++;
    if (got != want) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", req, got, want);
    end
  endtask

  // drive at negedge, model registers at posedge, compare at next negedge
  task automatic apply(input logic [NOPS*W-1:0] v, input logic r, input string req);
    opnd = v;
    rst  = r;
    exp_q.push_back(r ? 0 : ref_sum(v));
    @(negedge clk);
    check(req, longint'(sum_q), exp_q.pop_front());
  endtask

  function automatic logic [NOPS*W-1:0] rand_ops();
    logic [NOPS*W-1:0] v;
    for (int k = 0; k < NOPS*W/32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin : watchdog
    #(CLK_PER * 20000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : main
    logic [NOPS*W-1:0] v;
    @(negedge clk);
    apply(rand_ops(), 1'b1, "R5 reset");
    apply(rand_ops(), 1'b1, "R5 reset");

    apply('0, 1'b0, "R6 all zero");
    apply('1, 1'b0, "R7 all ones");
    check("R7 top bit set", longint'(sum_q[WR-1]), 1);

    for (int k = 0; k < NOPS; k++) v[k*W +: W] = W'(1);
    apply(v, 1'b0, "R8 all ones value");

    for (int k = 0; k < NOPS; k++) begin
      v = '0;
      v[k*W +: W] = '1;
      apply(v, 1'b0, "R1 single max operand");
    end

    for (int k = 0; k < NOPS; k++) v[k*W +: W] = (k % 2 == 0) ? 16'hAAAA : 16'h5555;
    apply(v, 1'b0, "R1 alternating");
    for (int k = 0; k < NOPS; k++) v[k*W +: W] = 16'h8000;
    apply(v, 1'b0, "R1 msb only");

    for (int n = 0; n < 400; n++) apply(rand_ops(), 1'b0, "R1 random");

    apply('1, 1'b1, "R5 mid-run reset");
    apply('1, 1'b0, "R7 after reset");

    // exhaustive compressor cell
    for (int m = 0; m < 32; m++) begin
      {ca, cb, cc, cd, cci} = 5'(m);
      #1;
      check("R2 weight", int'(cs) + 2*int'(ccar) + 2*int'(ccout),
            int'(ca) + int'(cb) + int'(cc) + int'(cd) + int'(cci));
      check("R3 cout", int'(ccout), (int'(ca) + int'(cb) + int'(cc)) >= 2 ? 1 : 0);
      check("R4 sum parity", int'(cs), int'(ca ^ cb ^ cc ^ cd ^ cci));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule